// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps a small set of recent page-to-frame translations. Each entry stores a virtual page number, a physical frame number, and three flags: valid, writable and executable. A request carries a virtual address and an access kind (load, store or instruction fetch). The page-number part of the address is compared against every stored entry at the same time. One clock later the block reports exactly one of three outcomes. A hit returns the physical address, built from the cached frame number and the untouched page offset. A miss means no valid entry holds the page. A protection fault means an entry holds the page but its flags forbid the access.

The fault on a store to a page that is not writable is how copy-on-write is built. A shared page is installed read-only, so the first store to it faults and the page can then be copied.

Translations enter the cache in two ways. A fill port installs a translation into a slot that the block chooses itself. A privileged write port sets one slot completely. Two more controls remove translations: one invalidates a single slot, and a flush clears every slot when the running process changes.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid and rsp_valid is low, so the first lookup of any page reports a miss.
- R2: A request sampled on one clock edge is answered on the next edge. rsp_valid follows req_valid with a delay of one cycle. Whenever rsp_valid is high, exactly one of rsp_hit, rsp_miss and rsp_fault is high; when rsp_valid is low, all three are low.
- R3: A request whose page matches a valid entry, and whose access the entry's flags allow, gives rsp_hit. rsp_paddr then equals the entry's frame number placed above the low OFS_W bits of req_vaddr.
- R4: A request whose page matches no valid entry gives rsp_miss. When rsp_hit is low, rsp_paddr is zero.
- R5: The access kind is a 2-bit code: 2'b00 load, 2'b01 store, 2'b10 fetch, 2'b11 treated as a load. A store to a matching entry whose writable flag is 0 gives rsp_fault. A load to the same entry hits.
- R6: A fetch (2'b10) to a matching entry whose executable flag is 0 gives rsp_fault. Loads and code 2'b11 need only the valid flag.
- R7: A fill picks its slot in this order. First, the slot already holding that page as a valid entry, which is overwritten. Otherwise the lowest-numbered invalid slot. Otherwise the slot named by a round-robin pointer. The pointer starts at 0 and advances by one, wrapping after ENTRIES-1, only when a fill uses it.
- R8: A direct write sets the page number, frame number, executable flag, writable flag and valid flag of slot wr_idx. Writing a valid flag of 0 removes that slot's translation.
- R9: An invalidate clears the valid flag of slot inv_idx, so a later lookup of that page misses.
- R10: A flush clears every valid flag. In the same cycle it overrides any fill, write or invalidate. Among the other three acting on the same slot, invalidate wins over write, and write wins over fill.
- R11: When a lookup and an update arrive in the same cycle, the lookup sees the contents from before the update.
- R12: Fills never create a second valid entry for the same page. Provided direct writes also keep pages unique, at most one entry matches any lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| req_valid | input | 1 | A lookup request is present this cycle |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_kind | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 load |
| fill_en | input | 1 | Install a translation into a slot the block chooses |
| fill_vpn | input | VA_W-OFS_W | Page number of the translation being filled |
| fill_pfn | input | PA_W-OFS_W | Frame number of the translation being filled |
| fill_x | input | 1 | Executable flag of the fill |
| fill_w | input | 1 | Writable flag of the fill |
| wr_en | input | 1 | Privileged write of one slot |
| wr_idx | input | clog2(ENTRIES) | Slot to write |
| wr_vpn | input | VA_W-OFS_W | Page number to write |
| wr_pfn | input | PA_W-OFS_W | Frame number to write |
| wr_x | input | 1 | Executable flag to write |
| wr_w | input | 1 | Writable flag to write |
| wr_v | input | 1 | Valid flag to write |
| inv_en | input | 1 | Invalidate one slot |
| inv_idx | input | clog2(ENTRIES) | Slot to invalidate |
| flush_en | input | 1 | Clear every valid flag |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | Translation found and the access is allowed |
| rsp_miss | output | 1 | No valid entry holds the page |
| rsp_fault | output | 1 | Entry found but its flags forbid the access |
| rsp_paddr | output | PA_W | Physical address on a hit, zero otherwise |

## Verification
A bad valid flag, page tag or frame field inside the cache appears at the ports on the first request to that page. It shows up one cycle after the request as the wrong outcome (hit where a miss is expected, or the reverse) or as a wrong rsp_paddr. A pointer in the wrong position takes longer to show. It is only seen once the cache is full and a fill evicts a different page than expected, so the bench fills the cache, drives evictions on purpose, and looks up the page expected to be gone and the page expected to survive. Bad flag bits show up as a fault where a hit is expected, or the reverse, on the first store or fetch to that page. A reference model in the bench follows every update, so all of these are caught at the response to the first affected lookup.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'b00,
    ACC_STORE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_LOAD2 = 2'b11
  } acc_kind_e;
endpackage

// File: rtl/xlat_rst_sync.sv
module xlat_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/xlat_match.sv
// Parallel tag compare across all slots, with a one-hot to index encoder.
module xlat_match #(
  parameter int N     = 8,
  parameter int TAG_W = 20,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vld_i,
  input  logic [TAG_W-1:0] tag_i [N],
  input  logic [TAG_W-1:0] key_i,
  output logic [N-1:0]     hit_vec_o,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_cmp
      assign hit_vec_o[g] = vld_i[g] && (tag_i[g] == key_i);
    end
  endgenerate

  assign any_o = |hit_vec_o;

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/xlat_victim.sv
// Chooses the slot for a fill: same page first, then the lowest free slot, then the pointer.
module xlat_victim #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     vld_i,
  input  logic             dup_any_i,
  input  logic [IDX_W-1:0] dup_idx_i,
  input  logic [IDX_W-1:0] rr_ptr_i,
  output logic [IDX_W-1:0] slot_o,
  output logic             use_rr_o
);
  logic             free_any;
  logic [IDX_W-1:0] free_idx;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_i[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    use_rr_o = 1'b0;
    if (dup_any_i)     slot_o = dup_idx_i;
    else if (free_any) slot_o = free_idx;
    else begin
      slot_o   = rr_ptr_i;
      use_rr_o = 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 28,
  parameter int OFS_W   = 12,
  parameter int ENTRIES = 8,
  localparam int VPN_W  = VA_W - OFS_W,
  localparam int PFN_W  = PA_W - OFS_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_x,
  input  logic             fill_w,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic             wr_x,
  input  logic             wr_w,
  input  logic             wr_v,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             flush_en,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr
);
  import xlat_pkg::*;

  logic rst_s_n;

  // Entry state
  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [ENTRIES-1:0] x_q, w_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q, rr_d;

  // Per-slot write data and enables
  logic [ENTRIES-1:0] ent_we;
  logic [ENTRIES-1:0] new_x, new_w;
  logic [VPN_W-1:0]   new_vpn [ENTRIES];
  logic [PFN_W-1:0]   new_pfn [ENTRIES];

  // Lookup and fill search results
  logic [ENTRIES-1:0] lk_hit_vec, fl_hit_vec;
  logic               lk_any, fl_any;
  logic [IDX_W-1:0]   lk_idx, fl_idx;
  logic [IDX_W-1:0]   fill_slot;
  logic               fill_use_rr;
  logic               fill_go;
  logic               perm_ok;

  // Response state
  logic              rv_q, rh_q, rm_q, rf_q;
  logic              rv_d, rh_d, rm_d, rf_d;
  logic [PA_W-1:0]   pa_q, pa_d;

  xlat_rst_sync u_rst (.clk(clk), .arst_n(rst_n), .srst_n(rst_s_n));

  xlat_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_lk_match (
    .vld_i(vld_q), .tag_i(vpn_q), .key_i(req_vaddr[VA_W-1:OFS_W]),
    .hit_vec_o(lk_hit_vec), .any_o(lk_any), .idx_o(lk_idx)
  );

  xlat_match #(.N(ENTRIES), .TAG_W(VPN_W)) u_fl_match (
    .vld_i(vld_q), .tag_i(vpn_q), .key_i(fill_vpn),
    .hit_vec_o(fl_hit_vec), .any_o(fl_any), .idx_o(fl_idx)
  );

  xlat_victim #(.N(ENTRIES)) u_victim (
    .vld_i(vld_q), .dup_any_i(fl_any), .dup_idx_i(fl_idx), .rr_ptr_i(rr_q),
    .slot_o(fill_slot), .use_rr_o(fill_use_rr)
  );

  assign fill_go = fill_en && !flush_en;

  // Permission check against the matching entry
  always_comb begin
    case (req_kind)
      ACC_STORE: perm_ok = w_q[lk_idx];
      ACC_FETCH: perm_ok = x_q[lk_idx];
      default:   perm_ok = 1'b1;
    endcase
  end

  // Response next state
  always_comb begin
    rv_d = req_valid;
    rh_d = req_valid && lk_any && perm_ok;
    rm_d = req_valid && !lk_any;
    rf_d = req_valid && lk_any && !perm_ok;
    pa_d = rh_d ? {pfn_q[lk_idx], req_vaddr[OFS_W-1:0]} : '0;
  end

  // Entry next state: fill, then write, then invalidate, then flush
  always_comb begin
    vld_d  = vld_q;
    rr_d   = rr_q;
    ent_we = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      new_vpn[i] = fill_vpn;
      new_pfn[i] = fill_pfn;
      new_x[i]   = fill_x;
      new_w[i]   = fill_w;
    end
    if (fill_go) begin
      ent_we[fill_slot] = 1'b1;
      vld_d[fill_slot]  = 1'b1;
      if (fill_use_rr)
        rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
    if (wr_en) begin
      ent_we[wr_idx]  = 1'b1;
      new_vpn[wr_idx] = wr_vpn;
      new_pfn[wr_idx] = wr_pfn;
      new_x[wr_idx]   = wr_x;
      new_w[wr_idx]   = wr_w;
      vld_d[wr_idx]   = wr_v;
    end
    if (inv_en)   vld_d[inv_idx] = 1'b0;
    if (flush_en) vld_d = '0;
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      vld_q <= '0;
      rr_q  <= '0;
      rv_q  <= 1'b0;
      rh_q  <= 1'b0;
      rm_q  <= 1'b0;
      rf_q  <= 1'b0;
      pa_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
      rv_q  <= rv_d;
      rh_q  <= rh_d;
      rm_q  <= rm_d;
      rf_q  <= rf_d;
      pa_q  <= pa_d;
    end
  end

  // Data registers, enabled per slot, not reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (ent_we[i]) begin
        vpn_q[i] <= new_vpn[i];
        pfn_q[i] <= new_pfn[i];
        x_q[i]   <= new_x[i];
        w_q[i]   <= new_w[i];
      end
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_hit   = rh_q;
  assign rsp_miss  = rm_q;
  assign rsp_fault = rf_q;
  assign rsp_paddr = pa_q;
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 28,
  parameter int OFS_W   = 12,
  parameter int ENTRIES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [VA_W-1:0]    req_vaddr,
  input logic               flush_en,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_miss,
  input logic               rsp_fault,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic [ENTRIES-1:0] lk_hit_vec
);
  p_req_answered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ({rsp_hit, rsp_miss, rsp_fault} == 3'b000));

  p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!rsp_hit || (rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]))));

  p_paddr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_paddr == '0));

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_en ##1 req_valid |=> rsp_miss);

  p_single_match_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));
endmodule

bind xlat_cache xlat_cache_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .ENTRIES(ENTRIES)
) chk_i (
  .clk(clk), .rst_n(rst_s_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .flush_en(flush_en), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
  .lk_hit_vec(lk_hit_vec)
);

// File: tb/xlat_cache_tb_top.sv
module xlat_cache_tb_top;
  localparam int VA_W = 32, PA_W = 28, OFS_W = 12, N = 8;
  localparam int VPN_W = VA_W - OFS_W, PFN_W = PA_W - OFS_W, IDX_W = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic             req_valid;
  logic [VA_W-1:0]  req_vaddr;
  logic [1:0]       req_kind;
  logic             fill_en, fill_x, fill_w;
  logic [VPN_W-1:0] fill_vpn;
  logic [PFN_W-1:0] fill_pfn;
  logic             wr_en, wr_x, wr_w, wr_v;
  logic [IDX_W-1:0] wr_idx, inv_idx;
  logic [VPN_W-1:0] wr_vpn;
  logic [PFN_W-1:0] wr_pfn;
  logic             inv_en, flush_en;
  logic             rsp_valid, rsp_hit, rsp_miss, rsp_fault;
  logic [PA_W-1:0]  rsp_paddr;

  xlat_cache #(.VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .ENTRIES(N)) dut_i (.*);

  // Reference model
  logic             m_vld [N];
  logic             m_x [N], m_w [N];
  logic [VPN_W-1:0] m_vpn [N];
  logic [PFN_W-1:0] m_pfn [N];
  int               m_ptr;

  // Pending expectation: code 0 idle, 1 hit, 2 miss, 3 fault
  int               p_code;
  logic [PA_W-1:0]  p_paddr;
  int               want;      // explicit directed expectation, 0 none
  string            want_tag;
  int               n_tests = 0, n_fail = 0;
  bit               done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int code, input logic [1:0] kind);
    if (code == 0) return "R2";
    if (code == 1) return "R3";
    if (code == 2) return "R4";
    return (kind == 2'b01) ? "R5" : "R6";
  endfunction

  task automatic idle_inputs();
    req_valid = 0; req_vaddr = '0; req_kind = 2'b00;
    fill_en = 0; fill_vpn = '0; fill_pfn = '0; fill_x = 0; fill_w = 0;
    wr_en = 0; wr_idx = '0; wr_vpn = '0; wr_pfn = '0; wr_x = 0; wr_w = 0; wr_v = 0;
    inv_en = 0; inv_idx = '0; flush_en = 0;
  endtask

  // One clock: predict from model (old contents), update model, then check at next negedge.
  task automatic cycle();
    int code, hit_i, slot;
    logic [1:0] kind;
    code = 0; hit_i = -1; kind = req_kind;
    p_paddr = '0;
    if (req_valid) begin
      for (int i = 0; i < N; i++)
        if (m_vld[i] && m_vpn[i] == req_vaddr[VA_W-1:OFS_W]) hit_i = i;
      if (hit_i < 0) code = 2;
      else if ((kind == 2'b01 && !m_w[hit_i]) || (kind == 2'b10 && !m_x[hit_i])) code = 3;
      else begin
        code = 1;
        p_paddr = {m_pfn[hit_i], req_vaddr[OFS_W-1:0]};
      end
    end
    p_code = code;
    if (flush_en) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
    end else begin
      if (fill_en) begin
        slot = -1;
        for (int i = 0; i < N; i++)
          if (m_vld[i] && m_vpn[i] == fill_vpn) slot = i;
        if (slot < 0)
          for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
        if (slot < 0) begin
          slot = m_ptr;
          m_ptr = (m_ptr + 1) % N;
        end
        m_vld[slot] = 1; m_vpn[slot] = fill_vpn; m_pfn[slot] = fill_pfn;
        m_x[slot] = fill_x; m_w[slot] = fill_w;
      end
      if (wr_en) begin
        m_vld[wr_idx] = wr_v; m_vpn[wr_idx] = wr_vpn; m_pfn[wr_idx] = wr_pfn;
        m_x[wr_idx] = wr_x; m_w[wr_idx] = wr_w;
      end
      if (inv_en) m_vld[inv_idx] = 0;
    end
    @(negedge clk);
    begin
      int got;
      got = rsp_hit ? 1 : rsp_miss ? 2 : rsp_fault ? 3 : 0;
      check(rsp_valid == (code != 0), tag_of(code, kind), "rsp_valid", rsp_valid, code != 0);
      check(got == code && (rsp_hit + rsp_miss + rsp_fault) <= 1, tag_of(code, kind),
            "outcome", got, code);
      check(rsp_paddr == p_paddr, tag_of(code, kind), "paddr", rsp_paddr, p_paddr);
      if (want != 0) check(got == want, want_tag, "directed outcome", got, want);
    end
    want = 0;
    idle_inputs();
  endtask

  task automatic look(input int vpn, input logic [1:0] kind, input int exp, input string tag);
    req_valid = 1;
    req_vaddr = {VPN_W'(vpn), OFS_W'($urandom)};
    req_kind  = kind;
    want = exp; want_tag = tag;
    cycle();
  endtask

  task automatic fill(input int vpn, input int pfn, input bit x, input bit w);
    fill_en = 1; fill_vpn = VPN_W'(vpn); fill_pfn = PFN_W'(pfn); fill_x = x; fill_w = w;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      m_vld[i] = 0; m_x[i] = 0; m_w[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0;
    end
    m_ptr = 0; want = 0; want_tag = "";
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    look(5, 2'b00, 2, "R1");

    // Fill pages 1..8 into slots 0..7; page 2 read-only, page 3 not executable
    for (int p = 1; p <= 8; p++) begin
      fill(p, 'h100 + p, p != 3, p != 2);
      cycle();
    end
    look(1, 2'b01, 1, "R3");
    look(2, 2'b01, 3, "R5");
    look(2, 2'b00, 1, "R5");
    look(3, 2'b10, 3, "R6");
    look(3, 2'b11, 1, "R6");
    look(9, 2'b00, 2, "R4");

    // R11: fill page 9 (evicts slot 0, page 1) with same-cycle lookup of page 9
    fill(9, 'h209, 1, 1);
    look(9, 2'b00, 2, "R11");
    look(9, 2'b00, 1, "R11");
    look(1, 2'b00, 2, "R7");

    // R7: refill of a present page overwrites it and does not move the pointer
    fill(4, 'h444, 1, 1);
    cycle();
    look(4, 2'b00, 1, "R7");
    look(5, 2'b00, 1, "R7");
    fill(10, 'h20a, 1, 1);   // pointer at 1: evicts page 2
    cycle();
    look(2, 2'b00, 2, "R7");
    look(10, 2'b00, 1, "R7");

    // R9: invalidate slot 4 (page 5), then a fill takes the free slot
    inv_en = 1; inv_idx = 3'd4;
    cycle();
    look(5, 2'b00, 2, "R9");
    fill(11, 'h20b, 1, 1);
    cycle();
    look(3, 2'b00, 1, "R7");
    look(6, 2'b00, 1, "R7");
    look(11, 2'b00, 1, "R7");

    // R8: direct write of slot 6 (page 7)
    wr_en = 1; wr_idx = 3'd6; wr_vpn = VPN_W'(12); wr_pfn = PFN_W'('h3ab);
    wr_x = 0; wr_w = 1; wr_v = 1;
    cycle();
    look(12, 2'b01, 1, "R8");
    look(12, 2'b10, 3, "R8");
    look(7, 2'b00, 2, "R8");
    wr_en = 1; wr_idx = 3'd6; wr_vpn = VPN_W'(12); wr_v = 0;
    cycle();
    look(12, 2'b00, 2, "R8");

    // R10: flush wins over a same-cycle fill
    flush_en = 1;
    fill(13, 'h20d, 1, 1);
    cycle();
    look(13, 2'b00, 2, "R10");
    look(9, 2'b00, 2, "R10");

    // R2: no request, no response
    want = 0;
    cycle();

    // Constrained random traffic
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom % 100;
      if (r < 40) begin
        fill(1 + $urandom % 16, $urandom, $urandom % 2, $urandom % 2);
      end else if (r < 50) begin
        wr_en = 1; wr_idx = IDX_W'($urandom); wr_vpn = VPN_W'(1 + $urandom % 16);
        wr_pfn = PFN_W'($urandom); wr_x = $urandom % 2; wr_w = $urandom % 2; wr_v = 1;
        for (int i = 0; i < N; i++)
          if (i != wr_idx && m_vld[i] && m_vpn[i] == wr_vpn) wr_v = 0;  // keep pages unique (R12)
      end else if (r < 58) begin
        inv_en = 1; inv_idx = IDX_W'($urandom);
      end else if (r < 60) begin
        flush_en = 1;
      end
      if ($urandom % 100 < 80) begin
        req_valid = 1;
        req_vaddr = {VPN_W'(1 + $urandom % 16), OFS_W'($urandom)};
        req_kind  = 2'($urandom);
      end
      cycle();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule